// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

The block adds two unsigned operands of `OPW` bits (8 by default) one bit position per clock cycle, least-significant bit first. A start request makes it capture both operands into right-shifting registers. On each add cycle the low bits of the two registers and a stored carry pass through a single full-adder cell. The sum bit shifts in from the top of a result register one bit wider than the operands, and the carry-out is written back into the carry flip-flop.

After the last bit pair, one more cycle shifts the final carry into the result register, so that its top bit holds the carry-out and its low bits hold the sum bits in order. The block then raises `done_o` and keeps the result on `sum_o`.

`start_i` and `done_o` are plain level signals, not a stream handshake, because each addition is one request answered by one held result. A new addition is accepted only after `start_i` has gone low and then high again. While `done_o` is high and `start_i` stays high, the block makes no progress and holds its output. This is the block's only form of back-pressure.

Top module: `serial_adder`

## Requirements
- R1: A synchronous active-high reset (`rst_i` high at a rising edge) leaves `done_o` at 0 and `sum_o` at 0 after that edge, including when it arrives in the middle of an addition.
- R2: When `done_o` is high, `sum_o` equals the unsigned sum of the two captured operands, OPW+1 bits wide.
- R3: `done_o` first reads high after the (OPW+3)th rising edge, counting as the first the edge at which the idle block samples `start_i` high (11 edges for OPW = 8).
- R4: The operands are captured only at the second of those edges. Changes on `a_i` or `b_i` after that edge have no effect on the result.
- R5: While `done_o` is high and `start_i` stays high, `done_o` stays high and `sum_o` stays unchanged, whatever `a_i` and `b_i` do.
- R6: When `start_i` is low while `done_o` is high, `done_o` is low after the next rising edge. `sum_o` keeps its value until the next addition begins.
- R7: Every addition starts with a carry-in of 0, whatever carry the previous addition left behind.
- R8: Bit OPW of `sum_o` (bit 8 by default) holds the carry-out of the most significant bit pair, so 255+1 yields 9'h100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Level request for a new addition |
| a_i | input | OPW | First operand, unsigned |
| b_i | input | OPW | Second operand, unsigned |
| done_o | output | 1 | High while the finished result is held |
| sum_o | output | OPW+1 | Result register, carry-out in the top bit |

## Verification
Two behaviours can fall in the same cycle. The first is the arrival of a result while a start request is still held high. The second is operand activity on the inputs while bits are being shifted. The bench keeps `start_i` high through the whole addition and for several cycles after `done_o` rises, changing `a_i` and `b_i` at random the whole time. It judges that `done_o` stays up and `sum_o` stays frozen, and that a result whose operands were inverted just after capture still matches the originally captured pair. A reset is also forced in the middle of an addition to confirm that the block returns to its cleared state.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_ADD  = 3'd2,
    ST_FIN  = 3'd3,
    ST_DONE = 3'd4
  } sa_state_e;

endpackage

// File: rtl/sa_shreg.sv
module sa_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] par_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o,
  output logic         lsb_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_q <= '0;
    end else if (load_i) begin
      q_q <= par_i;
    end else if (shift_i) begin
      q_q <= {ser_i, q_q[W-1:1]};
    end
  end

  assign q_o   = q_q;
  assign lsb_o = q_q[0];

  // capture and shift are distinct steps of one addition
  assert_load_shift_excl_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !(load_i && shift_i));

endmodule

// File: rtl/sa_full_adder.sv
module sa_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic cin_i,
  output logic s_o,
  output logic cout_o
);

  always_comb begin
    s_o    = x_i ^ y_i ^ cin_i;
    cout_o = (x_i & y_i) | (cin_i & (x_i ^ y_i));
  end

endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl #(
  parameter int OPW = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic load_o,
  output logic add_o,
  output logic fin_o,
  output logic done_o
);
  import serial_add_pkg::*;

  localparam int CNTW = $clog2(OPW) + 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(OPW - 1);

  sa_state_e       state_q, state_d;
  logic [CNTW-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOAD;
      ST_LOAD: state_d = ST_ADD;
      ST_ADD:  if (cnt_q == LAST) state_d = ST_FIN;
      ST_FIN:  state_d = ST_DONE;
      ST_DONE: if (!start_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOAD) begin
        cnt_q <= '0;
      end else if (state_q == ST_ADD) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign load_o = (state_q == ST_LOAD);
  assign add_o  = (state_q == ST_ADD);
  assign fin_o  = (state_q == ST_FIN);
  assign done_o = (state_q == ST_DONE);

  assert_add_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_ADD) |-> (cnt_q < CNTW'(OPW)));

  assert_load_to_add_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_LOAD) |=> (state_q == ST_ADD));

  assert_fin_after_add_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_FIN) |=> (state_q == ST_DONE));

endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int OPW = 8
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           start_i,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic           done_o,
  output logic [OPW:0]   sum_o
);

  localparam int SUMW = OPW + 1;

  logic load, add, fin;
  logic a_bit, b_bit, s_bit, c_out, carry_q;
  logic sum_in;
  logic [OPW-1:0]  a_q, b_q;
  logic [SUMW-1:0] sum_q;

  sa_ctrl #(.OPW(OPW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .start_i(start_i),
    .load_o (load),
    .add_o  (add),
    .fin_o  (fin),
    .done_o (done_o)
  );

  sa_shreg #(.W(OPW)) u_a (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load), .shift_i(add),
    .par_i(a_i), .ser_i(1'b0), .q_o(a_q), .lsb_o(a_bit)
  );

  sa_shreg #(.W(OPW)) u_b (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load), .shift_i(add),
    .par_i(b_i), .ser_i(1'b0), .q_o(b_q), .lsb_o(b_bit)
  );

  sa_full_adder u_fa (
    .x_i(a_bit), .y_i(b_bit), .cin_i(carry_q), .s_o(s_bit), .cout_o(c_out)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i || load) begin
      carry_q <= 1'b0;
    end else if (add) begin
      carry_q <= c_out;
    end
  end

  assign sum_in = fin ? carry_q : s_bit;

  sa_shreg #(.W(SUMW)) u_sum (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load), .shift_i(add | fin),
    .par_i('0), .ser_i(sum_in), .q_o(sum_q), .lsb_o()
  );

  assign sum_o = sum_q;

  // shadow of the captured operands, used only by the result check
  logic [SUMW-1:0] expect_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      expect_q <= '0;
    end else if (load) begin
      expect_q <= {1'b0, a_i} + {1'b0, b_i};
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (!done_o && sum_o == '0));

  assert_sum_matches_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(done_o) |-> (sum_o == expect_q));

  assert_hold_result_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && start_i) |=> (done_o && $stable(sum_o)));

  assert_release_done_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && !start_i) |=> !done_o);

  assert_carry_clear_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    load |=> (carry_q == 1'b0));

  assert_shift_drains_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    fin |=> (a_q == '0 && b_q == '0));

endmodule

// File: tb/serial_adder_test.sv
module serial_adder_test;

  localparam int OPW     = 8;
  localparam int CLK_PER = 10;
  localparam int WD_LIM  = 20000;

  logic           clk = 1'b0;
  logic           rst_i, start_i;
  logic [OPW-1:0] a_i, b_i;
  logic           done_o;
  logic [OPW:0]   sum_o;

  always #(CLK_PER/2) clk = ~clk;

  serial_adder #(.OPW(OPW)) uut (
    .clk_i(clk), .rst_i(rst_i), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .done_o(done_o), .sum_o(sum_o)
  );

  typedef struct {
    logic [OPW:0] val;
    string        tag;
  } exp_t;

  exp_t exp_q[$];

  int drv_checks = 0, drv_fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int wd_fails = 0;
  bit finished = 0;

  function automatic void summary();
    $display("== %0d vectors applied, %0d miscompares ==",
             drv_checks + mon_checks + wd_fails, drv_fails + mon_fails + wd_fails);
  endfunction

  // monitor: pop and compare whenever a result appears
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (done_o && !prev_done) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_fails++;
        $display("FAIL R2: result %h appeared with nothing expected", sum_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (sum_o !== e.val) begin
          mon_fails++;
          $display("FAIL %s: sum actual %h expected %h", e.tag, sum_o, e.val);
        end
      end
    end
    prev_done = done_o;
  end

  task automatic drv_check(input bit ok, input string tag, input int act, input int expv);
    drv_checks++;
    if (!ok) begin
      drv_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic run_add(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                         input string tag, input bit scramble, input int hold);
    logic [OPW:0] expv;
    int n;
    expv = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    a_i = a; b_i = b; start_i = 1'b1;
    exp_q.push_back('{expv, tag});
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
      // R4: operands were captured at edge 2; disturb them from here on
      if (scramble && n >= 2) begin
        a_i = $urandom; b_i = $urandom;
      end
    end while (!done_o && n < 40);
    drv_check(n == OPW + 3, "R3 latency", n, OPW + 3);
    // R5: hold with start high and wandering operands
    for (int i = 0; i < hold; i++) begin
      a_i = $urandom; b_i = $urandom;
      @(posedge clk); @(negedge clk);
      drv_check(done_o === 1'b1, "R5 done held", done_o, 1);
      drv_check(sum_o === expv, "R5 sum held", sum_o, expv);
    end
    // R6: release
    start_i = 1'b0;
    @(posedge clk); @(negedge clk);
    drv_check(done_o === 1'b0, "R6 done falls", done_o, 0);
    drv_check(sum_o === expv, "R6 sum kept", sum_o, expv);
    @(posedge clk); @(negedge clk);
    drv_check(sum_o === expv, "R6 sum kept idle", sum_o, expv);
  endtask

  initial begin
    rst_i = 1'b1; start_i = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    drv_check(done_o === 1'b0, "R1 reset done", done_o, 0);
    drv_check(sum_o === '0, "R1 reset sum", sum_o, 0);
    rst_i = 1'b0;

    run_add(8'd0,   8'd0,   "R2 zero",      1'b0, 1);
    run_add(8'd255, 8'd255, "R8 max+max",   1'b0, 2);
    run_add(8'd0,   8'd0,   "R7 after carry", 1'b0, 0);
    run_add(8'd255, 8'd1,   "R8 ripple",    1'b0, 1);
    run_add(8'd128, 8'd128, "R8 top carry", 1'b0, 0);
    run_add(8'd170, 8'd85,  "R2 alternate", 1'b1, 3);
    run_add(8'd200, 8'd99,  "R4 scrambled", 1'b1, 2);

    // start held high straight into a new request after a release
    for (int k = 0; k < 20; k++) begin
      run_add(8'($urandom), 8'($urandom), "R2 random", k[0], k % 3);
    end

    // R1: reset in the middle of an addition
    @(negedge clk);
    a_i = 8'd77; b_i = 8'd33; start_i = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_i = 1'b1; start_i = 1'b0;
    @(posedge clk); @(negedge clk);
    drv_check(done_o === 1'b0, "R1 mid reset done", done_o, 0);
    drv_check(sum_o === '0, "R1 mid reset sum", sum_o, 0);
    rst_i = 1'b0;
    repeat (15) @(posedge clk);
    @(negedge clk);
    drv_check(done_o === 1'b0, "R1 no late result", done_o, 0);

    run_add(8'd1, 8'd254, "R7 after reset", 1'b0, 1);
    drv_check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_LIM) @(posedge clk);
    if (!finished) begin
      wd_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule